// File: doc/BRIEF.md
# Scoped Cache Invalidate and Freeze Controller

This block holds the control register and the line bookkeeping for a small direct-mapped cache. The cache can serve instruction fetches and operand accesses together, or only one of the two. The tag, valid and line-kind storage sits inside the block. The data array, the refill bus and the return of hit data are outside it. Each lookup presents an address and an access kind. On the same cycle the block reports a hit, or it grants permission for the missing line to be installed. When it grants permission, the tag is written at the next clock edge.

Software writes the control register to enable the cache, pick its mode, freeze its contents or start an invalidate. An invalidate starts a sweep that visits every line index once. The sweep clears the valid bit of each line that lies inside the selected portion. In unified mode, that portion can be only the instruction lines or only the operand lines. The `busy` output stays high while the sweep runs. The invalidate bit clears itself when the sweep ends.

Top module: `cache_line_ctl`

## Requirements
- R1: After synchronous reset the control register reads 0, `busy` is 0 and every line is invalid, so the first enabled lookup to any address misses.
- R2: Fields of the 32-bit control register: bit 31 enable, bit 27 freeze, bit 24 invalidate, bit 21 instruction scope, bit 20 operand scope, bits [1:0] mode (00 unified, 01 instruction only, 10 operand only, 11 unified). All other bits read back 0. A write with bit 24 set while idle starts a sweep. `busy` is then high for exactly LINES cycles, bit 24 reads 1 during the sweep and 0 afterwards, and the other fields keep their written values.
- R3: Register writes that arrive while `busy` is high are ignored.
- R4: While `busy` is high, every lookup gives hit 0 and alloc 0 and installs nothing.
- R5: In unified mode, a sweep with only bit 21 set clears only lines installed by instruction lookups. Operand lines keep hitting.
- R6: In unified mode, a sweep with only bit 20 set clears only lines installed by operand lookups. Instruction lines keep hitting.
- R7: In unified mode, a sweep with both scope bits set, or with neither set, clears every line. In the instruction-only and operand-only modes every sweep clears every line, whatever the scope bits hold.
- R8: A lookup hits when the cache is enabled, idle and allows the access kind, and the line at index addr[4+IDX_W-1:4] is valid with a tag equal to the upper address bits. With 128 lines of 16 bytes, addresses 2048 bytes apart share one index. The kind recorded in the line does not affect the hit.
- R9: When freeze is clear, an allowed miss asserts alloc and installs the new tag and kind, replacing any valid line at that index. The next lookup of that address hits.
- R10: When freeze is set, a miss on a valid line gives alloc 0 and the old line keeps hitting. A miss on an invalid line still allocates.
- R11: A sweep started while freeze is set runs normally and leaves every selected line invalid. Those lines can then be refilled while frozen.
- R12: When the cache is disabled, or when the mode excludes the access kind, a lookup gives hit 0 and alloc 0 even if the line is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write value |
| cfg_rdata | output | 32 | Current control register value |
| busy | output | 1 | High while the invalidate sweep runs |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup byte address |
| lk_instr | input | 1 | 1 for an instruction fetch, 0 for an operand access |
| lk_hit | output | 1 | Lookup hits a valid matching line |
| lk_alloc | output | 1 | Miss is permitted to install the line |

## Verification
The bench runs scoped sweeps over a cache that holds instruction lines and operand lines together, then probes both kinds of line. A design that ignores the scope, or reads the wrong kind bit, either loses lines it should keep or keeps stale lines that then hit. It checks aliasing addresses 2048 bytes apart, which expose an index that is too wide or too narrow as false hits or missed replacements. Freeze is tested on a valid line and on an empty line, and a sweep is run while frozen. A design that displaces frozen lines, or that blocks refills after a frozen clear, gives the wrong alloc value. Lookups and register writes are issued in the middle of a sweep to catch state that a design installs or accepts while `busy` is high.

// File: rtl/clc_pkg.sv
package clc_pkg;

    localparam int CTL_W   = 32;
    localparam int EN_BIT  = 31;
    localparam int FRZ_BIT = 27;
    localparam int INV_BIT = 24;
    localparam int SCI_BIT = 21;
    localparam int SCD_BIT = 20;

    typedef enum logic [1:0] {
        MODE_UNIFIED = 2'b00,
        MODE_INSTR   = 2'b01,
        MODE_OPER    = 2'b10,
        MODE_UNI_ALT = 2'b11
    } mode_e;

    typedef struct packed {
        logic  en;
        logic  frz;
        logic  inv;
        logic  scope_i;
        logic  scope_d;
        mode_e mode;
    } ctl_t;

    function automatic ctl_t ctl_decode(input logic [CTL_W-1:0] w);
        ctl_t c;
        c.en      = w[EN_BIT];
        c.frz     = w[FRZ_BIT];
        c.inv     = w[INV_BIT];
        c.scope_i = w[SCI_BIT];
        c.scope_d = w[SCD_BIT];
        c.mode    = mode_e'(w[1:0]);
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] ctl_encode(input ctl_t c);
        logic [CTL_W-1:0] w;
        w          = '0;
        w[EN_BIT]  = c.en;
        w[FRZ_BIT] = c.frz;
        w[INV_BIT] = c.inv;
        w[SCI_BIT] = c.scope_i;
        w[SCD_BIT] = c.scope_d;
        w[1:0]     = c.mode;
        return w;
    endfunction

    function automatic logic is_unified(input mode_e m);
        return (m == MODE_UNIFIED) || (m == MODE_UNI_ALT);
    endfunction

    // Does a sweep with this configuration clear a line of this kind?
    function automatic logic sweep_selects(input ctl_t c, input logic line_instr);
        logic sel;
        if (!is_unified(c.mode))            sel = 1'b1;
        else if (c.scope_i && !c.scope_d)   sel = line_instr;
        else if (c.scope_d && !c.scope_i)   sel = !line_instr;
        else                                sel = 1'b1;
        return sel;
    endfunction

    function automatic logic kind_allowed(input mode_e m, input logic is_instr);
        logic ok;
        case (m)
            MODE_INSTR: ok = is_instr;
            MODE_OPER:  ok = !is_instr;
            default:    ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/clc_sweep.sv
module clc_sweep
    import clc_pkg::*;
#(
    parameter int LINES = 128,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CTL_W-1:0] cfg_wdata,
    output ctl_t             ctl,
    output logic             busy,
    output logic [IDX_W-1:0] sweep_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl       <= '0;
            busy      <= 1'b0;
            sweep_idx <= '0;
        end else if (busy) begin
            if (sweep_idx == LAST_IDX) begin
                busy      <= 1'b0;
                ctl.inv   <= 1'b0;
                sweep_idx <= '0;
            end else begin
                sweep_idx <= sweep_idx + 1'b1;
            end
        end else if (cfg_we) begin
            ctl       <= ctl_decode(cfg_wdata);
            busy      <= cfg_wdata[INV_BIT];
            sweep_idx <= '0;
        end
    end

endmodule

// File: rtl/clc_tag_array.sv
module clc_tag_array
    import clc_pkg::*;
#(
    parameter int LINES = 128,
    parameter int TAG_W = 21,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_t             ctl,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_kind,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag
);

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] kind_q;
    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] clr_vec;
    logic [LINES-1:0] set_vec;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign clr_vec[i] = clr_en && (clr_idx == IDX_W'(i)) && sweep_selects(ctl, kind_q[i]);
        assign set_vec[i] = wr_en && (wr_idx == IDX_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) valid_q <= '0;
        else     valid_q <= (valid_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            kind_q[wr_idx] <= wr_kind;
            tag_q[wr_idx]  <= wr_tag;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/clc_alloc_gate.sv
module clc_alloc_gate
    import clc_pkg::*;
#(
    parameter int TAG_W = 21
) (
    input  ctl_t             ctl,
    input  logic             busy,
    input  logic             lk_valid,
    input  logic             lk_instr,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             rd_valid,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit,
    output logic             alloc
);

    logic permit;
    logic match;

    always_comb begin
        permit = lk_valid && ctl.en && !busy && kind_allowed(ctl.mode, lk_instr);
        match  = rd_valid && (rd_tag == lk_tag);
        hit    = permit && match;
        alloc  = permit && !match && (!rd_valid || !ctl.frz);
    end

endmodule

// File: rtl/cache_line_ctl.sv
module cache_line_ctl
    import clc_pkg::*;
#(
    parameter int LINES      = 128,
    parameter int LINE_BYTES = 16,
    parameter int ADDR_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              busy,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_instr,
    output logic              lk_hit,
    output logic              lk_alloc
);

    localparam int IDX_W = $clog2(LINES);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    ctl_t             ctl;
    logic [IDX_W-1:0] sweep_idx;
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic             rd_valid;
    logic [TAG_W-1:0] rd_tag;
    logic             unused_offset;

    assign lk_idx        = lk_addr[OFF_W +: IDX_W];
    assign lk_tag        = lk_addr[ADDR_W-1 -: TAG_W];
    assign unused_offset = ^lk_addr[OFF_W-1:0];

    clc_sweep #(.LINES(LINES)) u_sweep (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .ctl       (ctl),
        .busy      (busy),
        .sweep_idx (sweep_idx)
    );

    clc_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .clr_en   (busy),
        .clr_idx  (sweep_idx),
        .wr_en    (lk_alloc),
        .wr_idx   (lk_idx),
        .wr_tag   (lk_tag),
        .wr_kind  (lk_instr),
        .rd_idx   (lk_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag)
    );

    clc_alloc_gate #(.TAG_W(TAG_W)) u_gate (
        .ctl      (ctl),
        .busy     (busy),
        .lk_valid (lk_valid),
        .lk_instr (lk_instr),
        .lk_tag   (lk_tag),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .hit      (lk_hit),
        .alloc    (lk_alloc)
    );

    assign cfg_rdata = ctl_encode(ctl);

endmodule

// File: rtl/clc_chk.sv
module clc_chk #(
    parameter int LINES = 128
) (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        busy,
    input logic        lk_valid,
    input logic        lk_hit,
    input logic        lk_alloc,
    input logic        line_valid
);

    localparam int CNT_W = $clog2(LINES + 1);
    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_cnt <= '0;
        else              run_cnt <= run_cnt + 1'b1;
    end

    // R2
    sweep_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && cfg_we && cfg_wdata[24]) |=> (busy && cfg_rdata[24]));

    // R2
    sweep_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_cnt == CNT_W'(LINES) && !cfg_rdata[24]));

    // R3
    busy_write_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(cfg_rdata[31:25]) && $stable(cfg_rdata[23:0])));

    // R4
    busy_lookup_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!lk_hit && !lk_alloc));

    // R10
    frozen_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && cfg_rdata[27] && line_valid) |-> !lk_alloc);

    // R8
    hit_alloc_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(lk_hit && lk_alloc));

endmodule

bind cache_line_ctl clc_chk #(.LINES(LINES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .busy       (busy),
    .lk_valid   (lk_valid),
    .lk_hit     (lk_hit),
    .lk_alloc   (lk_alloc),
    .line_valid (rd_valid)
);

// File: tb/tb_cache_line_ctl.sv
module tb_cache_line_ctl;

    localparam int LINES = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        busy;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_instr = 1'b0;
    logic        lk_hit;
    logic        lk_alloc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic        hit;
        logic        alloc;
        logic [31:0] addr;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    cache_line_ctl dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .busy      (busy),
        .lk_valid  (lk_valid),
        .lk_addr   (lk_addr),
        .lk_instr  (lk_instr),
        .lk_hit    (lk_hit),
        .lk_alloc  (lk_alloc)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: compare every lookup against the scoreboard, mid-cycle.
    always @(negedge clk) begin
        if (lk_valid && !rst) begin
            if (sb.size() == 0) begin
                check(1'b0, "scoreboard", {30'd0, lk_hit, lk_alloc}, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({lk_hit, lk_alloc} == {e.hit, e.alloc}, e.req,
                      {lk_addr[29:0], lk_hit, lk_alloc}, {e.addr[29:0], e.hit, e.alloc});
            end
        end
    end

    task automatic look(input logic [31:0] a, input logic ins, input logic h, input logic al, input string req);
        exp_t e;
        e.hit = h; e.alloc = al; e.addr = a; e.req = req;
        @(posedge clk); #1;
        sb.push_back(e);
        lk_valid = 1'b1; lk_addr = a; lk_instr = ins;
        @(posedge clk); #1;
        lk_valid = 1'b0;
    endtask

    task automatic cfg_write(input logic [31:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic sweep(input logic [31:0] d, input string req);
        int n;
        cfg_write(d);
        check(cfg_rdata[24] == 1'b1, {req, " inv bit set"}, cfg_rdata, d);
        n = 0;
        forever begin
            @(negedge clk);
            if (busy) n++;
            else break;
        end
        check(n == LINES, {req, " busy length"}, n, LINES);
        check(cfg_rdata == (d & ~32'h0100_0000), {req, " readback"}, cfg_rdata, d & ~32'h0100_0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cfg_rdata == 32'h0, "R1 reg", cfg_rdata, 32'h0);
        check(busy == 1'b0, "R1 busy", {31'd0, busy}, 32'd0);
        // R12 disabled cache
        look(32'h0000, 1, 0, 0, "R12 disabled");
        cfg_write(32'h8000_0000);
        look(32'h0000, 1, 0, 1, "R1 empty after reset");
        look(32'h0000, 1, 1, 0, "R8 hit");
        look(32'h0004, 0, 1, 0, "R8 kind ignored");
        look(32'h0010, 1, 0, 1, "R9 fill");
        look(32'h0020, 1, 0, 1, "R9 fill");
        look(32'h0030, 1, 0, 1, "R9 fill");
        look(32'h0100, 0, 0, 1, "R9 fill data");
        look(32'h0110, 0, 0, 1, "R9 fill data");
        look(32'h0800, 1, 0, 1, "R9 alias replace");
        look(32'h0000, 1, 0, 1, "R9 alias back");
        // R10 freeze
        cfg_write(32'h8800_0000);
        look(32'h0800, 1, 0, 0, "R10 no displace");
        look(32'h0000, 1, 1, 0, "R10 old kept");
        look(32'h0320, 0, 0, 1, "R10 empty fill");
        // R5 / R11 instruction-scope sweep while frozen
        sweep(32'h8920_0000, "R11 R2");
        look(32'h0100, 0, 1, 0, "R5 data kept");
        look(32'h0320, 0, 1, 0, "R5 data kept");
        look(32'h0010, 1, 0, 1, "R11 refill frozen");
        look(32'h0000, 1, 0, 1, "R11 refill frozen");
        look(32'h0010, 1, 1, 0, "R11 refilled hit");
        // R6 operand-scope sweep
        sweep(32'h8110_0000, "R6 R2");
        look(32'h0010, 1, 1, 0, "R6 instr kept");
        look(32'h0100, 0, 0, 1, "R6 data cleared");
        look(32'h0320, 0, 0, 1, "R6 data cleared");
        // R7 both scope bits
        sweep(32'h8130_0000, "R7 R2");
        look(32'h0000, 1, 0, 1, "R7 both clears instr");
        look(32'h0100, 0, 0, 1, "R7 both clears data");
        // R3 / R4 activity during a sweep with no scope bits
        cfg_write(32'h8100_0000);
        look(32'h0010, 1, 0, 0, "R4 lookup while busy");
        cfg_write(32'h0000_0000);
        wait_idle();
        check(cfg_rdata == 32'h8000_0000, "R3 write ignored", cfg_rdata, 32'h8000_0000);
        look(32'h0010, 1, 0, 1, "R4 nothing installed");
        look(32'h0000, 1, 0, 1, "R7 neither clears instr");
        look(32'h0100, 0, 0, 1, "R7 neither clears data");
        // R12 instruction-only mode
        cfg_write(32'h8000_0001);
        look(32'h0100, 0, 0, 0, "R12 data blocked");
        look(32'h0200, 1, 0, 1, "R12 instr fill");
        look(32'h0200, 1, 1, 0, "R12 instr hit");
        // R7 scope ignored outside unified mode
        sweep(32'h8110_0001, "R7 R2 nonunified");
        look(32'h0200, 1, 0, 1, "R7 scope ignored");
        // R12 operand-only mode
        cfg_write(32'h8000_0002);
        look(32'h0200, 1, 0, 0, "R12 instr blocked");
        look(32'h0100, 0, 0, 1, "R12 data fill");
        repeat (2) @(posedge clk);
        check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule